// File: doc/BRIEF.md
# Error Counter Threshold Crossing Interrupt

This block watches the two 8-bit error counters of a CAN node, one for transmit errors and one for receive errors. It raises a sticky bus-error flag whenever either counter crosses into a worse error state. There are two such levels: a warning level at 96 and an error-passive level at 128. The block detects crossings, not levels. Once software clears the flag, a counter that stays above a level it has already crossed does not raise the flag again. That level fires again only after the counter has dropped below it and then climbed back. Crossing the next, higher level also fires.

Each counter keeps one armed bit per level. A bit disarms when its crossing is seen and re-arms in the cycle after the counter reads below that level. Every armed bit starts disarmed at reset, so a counter already above a level when reset is released must first drop below that level. The flag shows a crossing one clock after the counter value is presented. All pins are plain control and status pins; no data stream passes through the block, so there is no valid/ready handshake. The interrupt request is the flag gated by an enable.

Top module: `errcnt_cross_irq`

## Requirements
- R1: During reset and in the first cycle after it, flag_o and irq_o are 0.
- R2: When an armed counter presents a value of 96 or more, flag_o is 1 from the next clock on. The value 96 itself counts as reaching the level.
- R3: While neither crossing nor clear occurs, flag_o holds its value. After a clear it stays 0 while the counter remains in the range 96..127.
- R4: A counter that reads below 96 for at least one cycle and then reads 96 or more sets flag_o again.
- R5: A counter reaching 128 or more sets flag_o even when its warning level is disarmed. The value 127 does not do so.
- R6: If a crossing and clr_i coincide in one cycle, flag_o is 1 in the next cycle.
- R7: A counter that jumps from below 96 to 128 or more in one update sets flag_o once. After a clear, flag_o stays 0 while that counter stays at or above 128.
- R8: irq_o is 1 exactly when flag_o is 1 and en_i is 1. en_i has no effect on flag_o.
- R9: The transmit and receive counters are tracked independently. A receive crossing sets flag_o while the transmit levels are disarmed, and it leaves the armed state of the transmit counter unchanged.
- R10: clr_i high with no crossing in that cycle makes flag_o 0 in the next cycle.
- R11: A counter held at or above a level from reset onward does not set flag_o until it has dropped below that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tx_cnt_i | input | 8 | Transmit error counter value |
| rx_cnt_i | input | 8 | Receive error counter value |
| clr_i | input | 1 | Software clear strobe for the flag |
| en_i | input | 1 | Interrupt request enable |
| flag_o | output | 1 | Sticky bus-error interrupt flag |
| irq_o | output | 1 | Interrupt request, flag gated by enable |

## Verification
The counters are stepped through several patterns:
- Slow climbs stop exactly at 95/96 and 127/128, which separates an off-by-one comparison from a correct one.
- Clears while a counter sits above a level show a level detector apart from a crossing detector.
- Dips of one cycle below a level confirm that re-arming happens.
- Single-step jumps across both levels, and crossings that coincide with a clear, expose double firing and the wrong priority between set and clear.
- Receive crossings taken while the transmit levels are disarmed show whether one counter's armed state leaks into the other.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;
  localparam int unsigned CNT_W_DEF   = 8;
  localparam int unsigned WARN_DEF    = 96;
  localparam int unsigned PASSIVE_DEF = 128;
  localparam int unsigned NUM_CNT     = 2;  // transmit, receive
  localparam int unsigned NUM_LVL     = 2;  // warning, passive

  function automatic int unsigned lvl_value(input int unsigned idx,
                                            input int unsigned warn,
                                            input int unsigned passive);
    return (idx == 0) ? warn : passive;
  endfunction
endpackage

// File: rtl/errcnt_arm_cell.sv
module errcnt_arm_cell #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LEVEL = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] LVL = CNT_W'(LEVEL);

  logic armed_q;
  logic reached;

  assign reached = (cnt_i >= LVL);
  assign fire_o  = armed_q & reached;

  // Arms while below the level, disarms once a crossing has been reported.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (!reached) armed_q <= 1'b1;
    else if (fire_o)   armed_q <= 1'b0;
  end
endmodule

// File: rtl/errcnt_flag_reg.sv
module errcnt_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // A set takes priority over a coincident clear.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/errcnt_cross_irq.sv
module errcnt_cross_irq
  import errcnt_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned WARN    = WARN_DEF,
  parameter int unsigned PASSIVE = PASSIVE_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             clr_i,
  input  logic             en_i,
  output logic             flag_o,
  output logic             irq_o
);
  localparam int unsigned NUM_CELL = NUM_CNT * NUM_LVL;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;
  logic [NUM_CELL-1:0]           fire_vec;
  logic                          set_any;

  assign cnt_vec[0] = tx_cnt_i;
  assign cnt_vec[1] = rx_cnt_i;

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      errcnt_arm_cell #(
        .CNT_W (CNT_W),
        .LEVEL (lvl_value(l, WARN, PASSIVE))
      ) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_i  (cnt_vec[c]),
        .fire_o (fire_vec[c*NUM_LVL + l])
      );
    end
  end

  // Several simultaneous crossings collapse into one flag set.
  assign set_any = |fire_vec;

  errcnt_flag_reg u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_any),
    .clr_i  (clr_i),
    .en_i   (en_i),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/errcnt_cross_chk.sv
module errcnt_cross_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_i,
  input logic en_i,
  input logic set_any,
  input logic flag_o,
  input logic irq_o
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |=> !flag_o);

  assert_set_visible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_any |=> flag_o);

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_any && clr_i) |=> flag_o);

  assert_clear_takes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_any && clr_i) |=> !flag_o);

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_any && !clr_i) |=> $stable(flag_o));

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && en_i));

  assert_irq_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o);
endmodule

bind errcnt_cross_irq errcnt_cross_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .en_i    (en_i),
  .set_any (set_any),
  .flag_o  (flag_o),
  .irq_o   (irq_o)
);

// File: tb/tb_errcnt_cross_irq.sv
`timescale 1ns/1ps
module tb_errcnt_cross_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_cnt = '0;
  logic [7:0] rx_cnt = '0;
  logic       clr = 1'b0;
  logic       en = 1'b1;
  logic       flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state: [counter][level]
  bit m_armed [2][2];
  bit m_flag;
  int levels [2] = '{96, 128};

  always #4 clk = ~clk;  // 125 MHz

  errcnt_cross_irq dut (
    .clk_i (clk), .rst_ni (rst_n), .tx_cnt_i (tx_cnt), .rx_cnt_i (rx_cnt),
    .clr_i (clr), .en_i (en), .flag_o (flag), .irq_o (irq)
  );

  task automatic compare(input string tag);
    checks++;
    if (flag !== m_flag) begin
      errors++;
      $display("FAIL %s flag actual=%0b expected=%0b", tag, flag, m_flag);
    end
    checks++;
    if (irq !== (m_flag & en)) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, m_flag & en);
    end
  endtask

  task automatic model_edge();
    int vals [2];
    bit ev;
    vals[0] = tx_cnt;
    vals[1] = rx_cnt;
    ev = 0;
    for (int c = 0; c < 2; c++) begin
      for (int l = 0; l < 2; l++) begin
        if (vals[c] < levels[l]) m_armed[c][l] = 1;
        else if (m_armed[c][l]) begin
          ev = 1;
          m_armed[c][l] = 0;
        end
      end
    end
    if (ev) m_flag = 1;
    else if (clr) m_flag = 0;
  endtask

  // Called at a negedge: drive, clock, update model, compare at next negedge.
  task automatic step(input int tx, input int rx, input bit c, input bit e,
                      input string tag);
    tx_cnt = 8'(tx);
    rx_cnt = 8'(rx);
    clr = c;
    en = e;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int l = 0; l < 2; l++) m_armed[c][l] = 0;
    m_flag = 0;
    tx_cnt = 8'd100;  // R11: counter already above warning during reset
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    step(100, 0, 0, 1, "R1 first cycle after reset");
    step(100, 0, 0, 1, "R11 held above since reset");
    step(50,  0, 0, 1, "R11 drop below");
    step(100, 0, 0, 1, "R11 fires after re-arm");
    // R10 clear, then R3 stays clear while above warning
    step(100, 0, 1, 1, "R10 clear");
    step(100, 0, 0, 1, "R3 stays clear");
    step(110, 0, 0, 1, "R3 stays clear higher");
    step(127, 0, 0, 1, "R5 127 does not fire");
    // R4 re-arm and exact boundary R2
    step(95,  0, 0, 1, "R4 dip below");
    step(96,  0, 0, 1, "R2 exactly 96 fires");
    step(96,  0, 0, 1, "R3 sticky");
    step(96,  0, 0, 0, "R8 enable low masks irq");
    step(96,  0, 0, 1, "R8 enable high");
    step(96,  0, 1, 0, "R10 clear with enable low");
    step(127, 0, 0, 1, "R5 127 no fire");
    step(128, 0, 0, 1, "R5 128 fires passive");
    step(128, 0, 1, 1, "R10 clear");
    step(200, 0, 0, 1, "R7 passive disarmed");
    // R9 receive counter independent of transmit
    step(200, 95, 0, 1, "R9 rx below");
    step(200, 96, 0, 1, "R9 rx warning fires");
    step(200, 96, 1, 1, "R10 clear");
    step(200, 130, 0, 1, "R9 rx passive fires");
    step(200, 130, 1, 1, "R10 clear");
    step(200, 130, 0, 1, "R9 both disarmed");
    // R6 set beats clear
    step(100, 130, 0, 1, "R6 tx re-arms passive");
    step(140, 130, 1, 1, "R6 set wins over clear");
    step(140, 130, 0, 1, "R6 flag held");
    // R7 jump across both thresholds
    step(10,  10, 1, 1, "R7 clear and arm");
    step(10,  10, 0, 1, "R7 idle");
    step(150, 10, 0, 1, "R7 jump sets");
    step(150, 10, 1, 1, "R7 clear");
    step(150, 10, 0, 1, "R7 single set only");
    step(250, 10, 0, 1, "R7 still no refire");
    step(10, 250, 0, 1, "R7 rx jump sets");
    step(10, 250, 1, 0, "R7 clear");
    step(10, 250, 0, 1, "R7 rx single set");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule